// File: doc/BRIEF.md
# Bus Wake-Up Payload Detector

This block watches the bytes of a received frame payload while the node sits in standby and looks for one fixed wake-up pattern. The pattern has three blocks, each of five 0xFF bytes followed by five 0x00 bytes, and then a closing run of six 0xFF bytes, for 36 bytes in all. Each byte arrives with a one-cycle valid strobe. A separate marker flags the start of each new frame.

When the last byte of the pattern arrives, the node is in standby and the supply is not in undervoltage, a latched bus-wake flag is set. The flag stays set until a transition-to-normal pulse clears it. While the flag is set and the active-low standby-control input is LOW, the block asks the pin logic to pull both the receive-data output and the error output LOW. Decoding of bus-level timing happens upstream. Only matching at byte level is done here.

Top module: `bus_wake_detector`

## Requirements
- R1: Bytes with `byte_vld` high are matched against the pattern. Index i (0 to 35) expects 0xFF when i >= 30 or when (i mod 10) < 5, and expects 0x00 otherwise. `wake_flag` goes high in the cycle after the clock edge that samples the 36th matching byte. After a completed pattern the match restarts at index 0.
- R2: A completed pattern sets `wake_flag` only if `in_standby` is high in the cycle of the final byte.
- R3: A completed pattern does not set `wake_flag` if `supply_uv` is high in the cycle of the final byte.
- R4: A high `go_normal` clears `wake_flag` at the next edge. The clear wins over a set in the same cycle.
- R5: `rxd_low_req` and `err_low_req` are both high exactly when `wake_flag` is high and `stby_ctl_n` is LOW. They follow `stby_ctl_n` without a register.
- R6: A valid byte that does not match its expected value restarts the match. If that byte is 0xFF it counts as index 0 of a new attempt, so the next byte is compared at index 1. Otherwise the next byte is compared at index 0.
- R7: `frame_sof` moves the match back to index 0. A valid byte in the same cycle is compared at index 0.
- R8: Once set, `wake_flag` stays high across any further bytes and any input values until `go_normal` or reset.
- R9: After reset `wake_flag` and both request outputs are low and the match starts at index 0. A byte presented with `byte_vld` low does not move the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | Payload byte valid strobe |
| byte_dat | input | 8 | Payload byte |
| frame_sof | input | 1 | Start-of-frame marker |
| in_standby | input | 1 | Node is in standby mode |
| supply_uv | input | 1 | Supply undervoltage present |
| stby_ctl_n | input | 1 | Standby-control input, active low |
| go_normal | input | 1 | Transition-to-normal pulse |
| wake_flag | output | 1 | Latched bus-wake flag |
| rxd_low_req | output | 1 | Request to drive receive data LOW |
| err_low_req | output | 1 | Request to drive the error output LOW |

## Verification
The bench drives each input vector half a cycle before a rising edge. `wake_flag` reacts to that vector one edge later, so the bench compares it at the following falling edge. The two request outputs depend on `stby_ctl_n` without a register, so they are compared at that same falling edge against the freshly registered flag and the level of `stby_ctl_n` currently applied. The bench reference model advances by exactly one state per step. Each check therefore compares against the state that the clock edge produced.

// File: rtl/wkp_pkg.sv
package wkp_pkg;

  // Expected byte at pattern index idx: reps blocks of (run_len high,
  // run_len low), then a tail of high bytes.
  function automatic logic [7:0] wkp_expected(input int unsigned idx,
                                              input int unsigned run_len,
                                              input int unsigned reps,
                                              input logic [7:0]  hi,
                                              input logic [7:0]  lo);
    if (idx >= 2 * run_len * reps) return hi;
    return ((idx % (2 * run_len)) < run_len) ? hi : lo;
  endfunction

endpackage

// File: rtl/wkp_rst_sync.sv
module wkp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/wkp_matcher.sv
module wkp_matcher
  import wkp_pkg::*;
#(
  parameter int unsigned RUN_LEN  = 5,
  parameter int unsigned REPEATS  = 3,
  parameter int unsigned TAIL_LEN = 6,
  parameter logic [7:0]  HI_BYTE  = 8'hFF,
  parameter logic [7:0]  LO_BYTE  = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  input  logic       frame_sof,
  output logic       pat_hit
);
  localparam int unsigned PAT_LEN = 2 * RUN_LEN * REPEATS + TAIL_LEN;
  localparam int unsigned POS_W   = $clog2(PAT_LEN + 1);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(PAT_LEN - 1);

  logic [POS_W-1:0] pos_q, pos_d, eff_pos;
  logic [7:0]       exp_b;
  logic             pos_en;

  always_comb begin
    eff_pos = frame_sof ? '0 : pos_q;
    exp_b   = wkp_expected(32'(eff_pos), RUN_LEN, REPEATS, HI_BYTE, LO_BYTE);
    pat_hit = 1'b0;
    pos_d   = pos_q;
    pos_en  = byte_vld | frame_sof;
    if (byte_vld) begin
      if (byte_dat == exp_b) begin
        if (eff_pos == LAST_POS) begin
          pat_hit = 1'b1;
          pos_d   = '0;
        end else begin
          pos_d = eff_pos + POS_W'(1);
        end
      end else begin
        pos_d = (byte_dat == HI_BYTE) ? POS_W'(1) : '0;
      end
    end else if (frame_sof) begin
      pos_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pos_q <= '0;
    else if (pos_en) pos_q <= pos_d;
  end

  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= LAST_POS);
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !frame_sof && byte_dat != HI_BYTE && byte_dat != LO_BYTE)
      |=> (pos_q == '0));
  // R7
  sof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_sof && !byte_vld) |=> (pos_q == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_vld && !frame_sof) |=> $stable(pos_q));
endmodule

// File: rtl/wkp_flag.sv
module wkp_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic pat_hit,
  input  logic in_standby,
  input  logic supply_uv,
  input  logic go_normal,
  output logic wake_flag
);
  logic flag_q, flag_d, flag_en, set_ok;

  always_comb begin
    set_ok  = pat_hit & in_standby & ~supply_uv;
    flag_en = go_normal | set_ok;
    flag_d  = go_normal ? 1'b0 : 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign wake_flag = flag_q;

  // R2
  no_set_outside_stby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_standby && !flag_q) |=> !flag_q);
  // R3
  no_set_uv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (supply_uv && !flag_q) |=> !flag_q);
  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_normal |=> !flag_q);
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !go_normal) |=> flag_q);
endmodule

// File: rtl/wkp_pin_req.sv
module wkp_pin_req (
  input  logic wake_flag,
  input  logic stby_ctl_n,
  output logic rxd_low_req,
  output logic err_low_req
);
  logic drive_low;

  always_comb begin
    drive_low   = wake_flag & ~stby_ctl_n;
    rxd_low_req = drive_low;
    err_low_req = drive_low;
  end
endmodule

// File: rtl/bus_wake_detector.sv
module bus_wake_detector #(
  parameter int unsigned RUN_LEN    = 5,
  parameter int unsigned REPEATS    = 3,
  parameter int unsigned TAIL_LEN   = 6,
  parameter logic [7:0]  HI_BYTE    = 8'hFF,
  parameter logic [7:0]  LO_BYTE    = 8'h00,
  parameter int unsigned SYNC_STAGE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld,
  input  logic [7:0] byte_dat,
  input  logic       frame_sof,
  input  logic       in_standby,
  input  logic       supply_uv,
  input  logic       stby_ctl_n,
  input  logic       go_normal,
  output logic       wake_flag,
  output logic       rxd_low_req,
  output logic       err_low_req
);
  logic rst_n_s;
  logic pat_hit;

  wkp_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  wkp_matcher #(
    .RUN_LEN(RUN_LEN), .REPEATS(REPEATS), .TAIL_LEN(TAIL_LEN),
    .HI_BYTE(HI_BYTE), .LO_BYTE(LO_BYTE)
  ) u_match (
    .clk(clk), .rst_n(rst_n_s), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .frame_sof(frame_sof), .pat_hit(pat_hit)
  );

  wkp_flag u_flag (
    .clk(clk), .rst_n(rst_n_s), .pat_hit(pat_hit), .in_standby(in_standby),
    .supply_uv(supply_uv), .go_normal(go_normal), .wake_flag(wake_flag)
  );

  wkp_pin_req u_req (
    .wake_flag(wake_flag), .stby_ctl_n(stby_ctl_n),
    .rxd_low_req(rxd_low_req), .err_low_req(err_low_req)
  );

  // R5
  req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !wake_flag |-> (!rxd_low_req && !err_low_req));
  // R5
  req_ctl_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    stby_ctl_n |-> (!rxd_low_req && !err_low_req));
endmodule

// File: tb/bus_wake_detector_tb.sv
`timescale 1ns/1ps
module bus_wake_detector_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_vld, frame_sof, in_standby, supply_uv, stby_ctl_n, go_normal;
  logic [7:0] byte_dat;
  logic       wake_flag, rxd_low_req, err_low_req;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned mpos  = 0;
  bit          mflag = 1'b0;
  bit          done  = 1'b0;

  always #4 clk = ~clk;

  bus_wake_detector u_dut (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .frame_sof(frame_sof), .in_standby(in_standby), .supply_uv(supply_uv),
    .stby_ctl_n(stby_ctl_n), .go_normal(go_normal), .wake_flag(wake_flag),
    .rxd_low_req(rxd_low_req), .err_low_req(err_low_req)
  );

  // Pattern as stated in R1
  function automatic logic [7:0] pat(input int unsigned i);
    if (i >= 30 || (i % 10) < 5) return 8'hFF;
    return 8'h00;
  endfunction

  task automatic check(input string tag);
    bit exp_req;
    exp_req = mflag && !stby_ctl_n;
    n_vec++;
    if (wake_flag !== mflag || rxd_low_req !== exp_req || err_low_req !== exp_req) begin
      n_bad++;
      $display("FAIL %s: flag/rxd/err = %b%b%b expected %b%b%b", tag,
               wake_flag, rxd_low_req, err_low_req, mflag, exp_req, exp_req);
    end
  endtask

  // Drive at falling edge, update model, check at next falling edge.
  task automatic step(input bit vld, input logic [7:0] dat, input bit sof,
                      input bit stby, input bit uv, input bit ctln,
                      input bit gon, input string tag);
    int unsigned eff;
    bit hit;
    byte_vld = vld; byte_dat = dat; frame_sof = sof; in_standby = stby;
    supply_uv = uv; stby_ctl_n = ctln; go_normal = gon;
    eff = sof ? 0 : mpos;
    hit = 1'b0;
    if (vld) begin
      if (dat == pat(eff)) begin
        if (eff == 35) begin hit = 1'b1; mpos = 0; end
        else mpos = eff + 1;
      end else begin
        mpos = (dat == 8'hFF) ? 1 : 0;
      end
    end else if (sof) begin
      mpos = 0;
    end
    if (gon) mflag = 1'b0;
    else if (hit && stby && !uv) mflag = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic send_range(input int unsigned lo, input int unsigned hi,
                            input bit stby, input bit uv, input string tag);
    for (int unsigned i = lo; i <= hi; i++)
      step(1'b1, pat(i), 1'b0, stby, uv, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; byte_vld = 0; byte_dat = 0; frame_sof = 0; in_standby = 1;
    supply_uv = 0; stby_ctl_n = 0; go_normal = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 reset");

    // R1/R5: full pattern in standby, requests follow stby_ctl_n
    send_range(0, 34, 1, 0, "R1 partial");
    step(1, pat(35), 0, 1, 0, 0, 0, "R1 final byte");
    step(0, 8'h5A, 0, 1, 0, 1, 0, "R5 ctl high");
    step(0, 8'h5A, 0, 1, 0, 0, 0, "R5 ctl low");
    // R8: flag holds across junk and a second pattern
    step(1, 8'h33, 0, 0, 1, 0, 0, "R8 junk");
    send_range(0, 35, 0, 1, "R8 hold");
    // R4: clear
    step(0, 8'h00, 0, 1, 0, 0, 1, "R4 clear");
    // R2: not in standby
    send_range(0, 35, 0, 0, "R2 no standby");
    // R3: undervoltage
    send_range(0, 35, 1, 1, "R3 undervoltage");
    // R4: clear wins over simultaneous set
    send_range(0, 34, 1, 0, "R4 prefix");
    step(1, pat(35), 0, 1, 0, 0, 1, "R4 clear priority");
    // R6: mismatching 0xFF counts as first byte
    send_range(0, 4, 1, 0, "R6 prefix");
    step(1, 8'hFF, 0, 1, 0, 0, 0, "R6 ff restart");
    send_range(1, 35, 1, 0, "R6 resume at 1");
    step(0, 0, 0, 1, 0, 0, 1, "R4 clear");
    // R6: other mismatch restarts at 0
    send_range(0, 12, 1, 0, "R6 prefix2");
    step(1, 8'h5A, 0, 1, 0, 0, 0, "R6 bad byte");
    send_range(1, 35, 1, 0, "R6 no false hit");
    // R7: frame start resets mid-pattern, coincident byte at index 0
    send_range(0, 20, 1, 0, "R7 prefix");
    step(0, 8'h00, 1, 1, 0, 0, 0, "R7 sof alone");
    send_range(21, 35, 1, 0, "R7 no false hit");
    send_range(0, 20, 1, 0, "R7 prefix2");
    step(1, 8'hFF, 1, 1, 0, 0, 0, "R7 sof with byte");
    send_range(1, 35, 1, 0, "R7 hit after sof");
    step(0, 0, 0, 1, 0, 0, 1, "R4 clear");
    // R9: invalid bytes are ignored
    send_range(0, 17, 1, 0, "R9 prefix");
    for (int k = 0; k < 4; k++) step(0, 8'h5A, 0, 1, 0, 0, 0, "R9 idle");
    send_range(18, 35, 1, 0, "R9 hit");

    // Constrained random mix
    begin
      int unsigned sidx = 0;
      for (int n = 0; n < 4000; n++) begin
        bit vld, sof, stby, uv, ctln, gon;
        logic [7:0] d;
        vld  = ($urandom % 100) < 85;
        sof  = ($urandom % 100) < 2;
        stby = ($urandom % 100) < 80;
        uv   = ($urandom % 100) < 10;
        ctln = $urandom % 2;
        gon  = ($urandom % 100) < 3;
        if (sof) sidx = 0;
        d = (($urandom % 100) < 95) ? pat(sidx) : 8'($urandom);
        if (vld) sidx = (sidx + 1) % 36;
        step(vld, d, sof, stby, uv, ctln, gon, "R1 random");
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule